// File: doc/BRIEF.md
# Memory-Backed Fixed Delay Line

This block delays a continuous stream of words by a fixed number of clock cycles. The words are not moved through a chain of registers. They are written once into a two-port storage array and read back later. Only two address counters move: one picks the entry to be written, the other picks the entry to be read. Each clock cycle one word enters and one word leaves. The delay is set by the depth of the array, which is a power of two (`DEPTH = 2**AW`). The block suits long delays, where a register chain of the same length would cost too much area.

A small controller has two states. In FILL the storage does not yet hold valid history, so the output is held at zero. In RUN the output register takes the word read from the array. The transition FILL_TO_RUN fires on the clock edge at which the read counter points at the last entry. The transition RUN_HOLD keeps the controller in RUN until the next reset. A synchronous reset returns the controller to FILL from either state (ANY_TO_FILL).

Top module: `ram_delay_line`

## Requirements
- R1: In RUN, the word on `dout` after clock edge k equals the `din` word sampled at edge k-(DEPTH-1). The total delay is therefore DEPTH-1 cycles, and this includes the registered read.
- R2: While `rst` is high at a clock edge, `dout` becomes all zeros after that edge. The read address becomes 0 and the write address becomes all ones.
- R3: The write address is always one entry behind the read address, modulo DEPTH, so the two ports never address the same entry.
- R4: Both addresses increase by one on every clock edge that has `rst` low, and they wrap from DEPTH-1 to 0. The delay therefore holds over many passes through the array.
- R5: For the first DEPTH-1 edges after reset is released, the controller stays in FILL and `dout` stays all zeros. It enters RUN on the edge at which the read address equals DEPTH-1.
- R6: Once in RUN, the controller stays in RUN until `rst` is asserted. A reset in the middle of a run returns it to FILL and restarts the zero-output phase of R5.
- R7: Every bit of the W-bit word is carried independently. All-zero, all-one, alternating and walking-one words come out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Clock; all state changes on its rising edge |
| rst  | input  | 1 | Synchronous reset, active high |
| din  | input  | W | Word written into the array each cycle |
| dout | output | W | Registered word read from the array, DEPTH-1 cycles old |

## Verification
The bench builds the block with AW=3 (DEPTH=8, delay 7) and W=12. A shallow array lets about two hundred words wrap the counters more than twenty times, which exercises the modulo addressing of R4 many times over. The short delay also makes the FILL_TO_RUN boundary and a reset in the middle of a run (R6) quick to reach. The 12-bit word is wide enough for walking-one and alternating patterns to show a swapped or stuck bit (R7).

// File: rtl/rdl_pkg.sv
package rdl_pkg;

    typedef enum logic [0:0] {
        RDL_FILL = 1'b0,
        RDL_RUN  = 1'b1
    } rdl_state_e;

endpackage

// File: rtl/rdl_ptr.sv
module rdl_ptr #(
    parameter int AW = 4,
    parameter logic [AW-1:0] START = '0
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] STEP = AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= START;
        end else begin
            addr <= addr + STEP;
        end
    end

endmodule

// File: rtl/rdl_mem.sv
module rdl_mem #(
    parameter int AW = 4,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    input  logic          load,
    output logic [W-1:0]  rdata
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        store[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (load) begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/rdl_ctrl.sv
module rdl_ctrl
    import rdl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_at_last,
    output rdl_state_e state,
    output logic       load
);

    rdl_state_e state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RDL_FILL;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RDL_FILL: state_nx = rd_at_last ? RDL_RUN : RDL_FILL;
            RDL_RUN:  state_nx = RDL_RUN;
            default:  state_nx = RDL_FILL;
        endcase
    end

    always_comb begin
        load = 1'b0;
        unique case (state)
            RDL_FILL: load = rd_at_last;
            RDL_RUN:  load = 1'b1;
            default:  load = 1'b0;
        endcase
    end

endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line
    import rdl_pkg::*;
#(
    parameter int AW = 4,
    parameter int W  = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam logic [AW-1:0] FIRST = '0;
    localparam logic [AW-1:0] LAST  = '1;

    logic [AW-1:0] rd_addr;
    logic [AW-1:0] wr_addr;
    logic          rd_at_last;
    logic          load;
    rdl_state_e    state;

    rdl_ptr #(.AW(AW), .START(FIRST)) u_rd_ptr (
        .clk  (clk),
        .rst  (rst),
        .addr (rd_addr)
    );

    rdl_ptr #(.AW(AW), .START(LAST)) u_wr_ptr (
        .clk  (clk),
        .rst  (rst),
        .addr (wr_addr)
    );

    assign rd_at_last = (rd_addr == LAST);

    rdl_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rd_at_last (rd_at_last),
        .state      (state),
        .load       (load)
    );

    rdl_mem #(.AW(AW), .W(W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .waddr (wr_addr),
        .wdata (din),
        .raddr (rd_addr),
        .load  (load),
        .rdata (dout)
    );

endmodule

// File: rtl/rdl_checker.sv
module rdl_checker
    import rdl_pkg::*;
#(
    parameter int AW = 4,
    parameter int W  = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  dout,
    input logic [AW-1:0] rd_addr,
    input logic [AW-1:0] wr_addr,
    input rdl_state_e    state
);

    assert_reset_state_R2: assert property (@(posedge clk)
        rst |=> (rd_addr == '0 && wr_addr == '1 && dout == '0 && state == RDL_FILL));

    assert_ptr_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (AW'(rd_addr - wr_addr) == AW'(1)));

    assert_rd_step_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (rd_addr == AW'($past(rd_addr) + AW'(1))));

    assert_wr_step_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (wr_addr == AW'($past(wr_addr) + AW'(1))));

    assert_fill_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (state == RDL_FILL) |-> (dout == '0));

    assert_fill_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (state == RDL_FILL && rd_addr == '1) |=> (state == RDL_RUN));

    assert_fill_stay_R5: assert property (@(posedge clk) disable iff (rst)
        (state == RDL_FILL && rd_addr != '1) |=> (state == RDL_FILL));

    assert_run_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == RDL_RUN) |=> (state == RDL_RUN));

endmodule

bind ram_delay_line rdl_checker #(.AW(AW), .W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .dout    (dout),
    .rd_addr (rd_addr),
    .wr_addr (wr_addr),
    .state   (state)
);

// File: tb/ram_delay_line_tb.sv
module ram_delay_line_tb;

    localparam int AW    = 3;
    localparam int W     = 12;
    localparam int DEPTH = 1 << AW;
    localparam int LAT   = DEPTH - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;

    logic [W-1:0] expq [$];
    logic         mon_en = 1'b0;
    int           pops_since_rst = 0;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    ram_delay_line #(.AW(AW), .W(W)) u_dut (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .dout (dout)
    );

    // Checks a value and records the result under the tag of its requirement.
    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dout=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: presents one word, pushes its expected echo, waits for the next falling edge.
    task automatic drive(input logic [W-1:0] v);
        din = v;
        expq.push_back(v);
        mon_en = 1'b1;
        @(negedge clk);
    endtask

    // Reset at a falling edge, checks the cleared output, then primes the
    // scoreboard with LAT zeros for the fill phase (R5).
    task automatic do_reset(input string tag);
        rst = 1'b1;
        mon_en = 1'b0;
        expq.delete();
        repeat (2) @(posedge clk);
        #2;
        check(tag, dout, '0);
        @(negedge clk);
        rst = 1'b0;
        pops_since_rst = 0;
        for (int i = 0; i < LAT; i++) expq.push_back('0);
    endtask

    // Monitor: after each rising edge, pops and compares one expected word.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_en && expq.size() > 0) begin
                logic [W-1:0] e;
                e = expq.pop_front();
                if (pops_since_rst < LAT) check("R5 fill", dout, e);
                else check("R1 R3 R4 R7 delay", dout, e);
                pops_since_rst++;
            end
        end
    end

    initial begin
        @(negedge clk);
        do_reset("R2 reset");
        // Counting words across many wraps (R1, R4).
        for (int i = 0; i < 60; i++) drive(W'(i * 37 + 5));
        // Full-width patterns (R7).
        for (int i = 0; i < 24; i++) begin
            case (i % 4)
                0: drive('0);
                1: drive('1);
                2: drive({(W/2){2'b10}});
                default: drive({(W/2){2'b01}});
            endcase
        end
        for (int i = 0; i < W; i++) drive(W'(1) << i);
        // Reset in the middle of a run returns to the fill phase (R6).
        do_reset("R6 midrun reset");
        begin
            logic [W-1:0] lf;
            lf = 12'hACE;
            for (int i = 0; i < 80; i++) begin
                lf = {lf[W-2:0], lf[W-1] ^ lf[5] ^ lf[3] ^ lf[0]};
                drive(lf);
            end
        end
        // Drain the remaining expected words with a steady input.
        for (int i = 0; i < LAT; i++) drive(12'h5A5);
        mon_en = 1'b0;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule